// File: doc/BRIEF.md
# Channel Status Block Decoder

This block assembles the 192-bit channel status block that an AES3 or S/PDIF-style serial audio stream carries, one bit per subframe. An upstream frame decoder hands it one strobe per subframe. Each strobe carries the channel status bit, a tag that says whether the subframe is A (left) or B (right), and a marker that is set on the first frame of each block. A select input picks which of the two subframes is collected. The other subframe is ignored completely.

When a block-start marker arrives on the selected subframe and exactly 192 bits were collected since the previous marker, the block just completed is decoded. The block then issues a one-cycle block-rate strobe and updates all of its outputs in the same cycle. The outputs are a consumer/professional indicator and five flags. The meaning of the flags changes with the mode. In consumer mode they report audio/non-audio, copy permission, pre-emphasis, original/copy and whether a category is set. In professional mode they report audio/non-audio, the two emphasis field bits, an inverted bit 9, and the result of an 8-bit CRC over the block. A block that is cut short or that runs past 192 bits is dropped, and the outputs keep their last values.

Top module: `cs_block_decoder`

## Requirements
- R1: Only strobes whose tag `sf_is_b` equals `chan_sel` are collected (0 selects subframe A, 1 selects subframe B). Subframes of the other tag have no effect on any output.
- R2: `mode_consumer` equals the inverse of block bit 0 (byte 0 bit 0). 1 means consumer and 0 means professional, and this value picks the flag mapping. Bit n of the block is the n-th collected bit after the marker, counting from 0, so that each byte is LSB first.
- R3: In consumer mode the flags are: `cs_flags[0]` = bit 1 (1 = non-audio), `cs_flags[1]` = inverse of bit 2 (1 = copy inhibited), `cs_flags[2]` = inverse of bit 3 (0 = pre-emphasis present), `cs_flags[3]` = bit 15 (1 = copy), and `cs_flags[4]` = OR of category bits 8 to 14 (0 = the all-zero category).
- R4: In professional mode the flags are: `cs_flags[0]` = bit 1, `cs_flags[1]` = bit 2, `cs_flags[2]` = bit 3, and `cs_flags[3]` = inverse of bit 9.
- R5: In professional mode `cs_flags[4]` is 1 when the CRC passes and 0 when it fails. The CRC uses polynomial x^8+x^4+x^3+x^2+1 and is preset to 0xFF. It runs over bits 0 to 183 in arrival order in reflected form: feedback = bit XOR crc[0], then shift right, then XOR with 0xB8 when the feedback is 1. The CRC passes when the result equals bits 184 to 191, with bit 184+j compared against crc bit j.
- R6: A marker on a selected subframe that follows exactly 192 collected bits raises `blk_stb` for exactly one cycle, in the cycle after the strobe is sampled. All outputs take the new values in that same cycle.
- R7: A marker that arrives before 192 bits have been collected restarts the count at bit 0 and produces no strobe. The outputs hold their values.
- R8: A block is not published, and the outputs hold, when it received more than 192 bits before its closing marker, or when it was not opened by a marker after reset.
- R9: After reset, `cs_flags` = 0, `mode_consumer` = 1 and `blk_stb` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_valid | input | 1 | One-cycle strobe, one per subframe |
| sf_cbit | input | 1 | Channel status bit of this subframe |
| sf_is_b | input | 1 | Subframe tag: 0 = A (left), 1 = B (right) |
| sf_blk_start | input | 1 | Set on the first frame of a channel status block |
| chan_sel | input | 1 | Subframe to decode: 0 = A, 1 = B |
| cs_flags | output | 5 | Decoded flags; meaning set by mode_consumer |
| mode_consumer | output | 1 | 1 = consumer block, 0 = professional block |
| blk_stb | output | 1 | One-cycle pulse when new decoded values appear |

## Verification
The hardest situations to reach are the ones where a block must be withheld: a marker that arrives after fewer than 192 bits, a block that overruns to 193 bits, and a stream that starts without a marker after reset. Each needs an exact frame count from the stimulus. The bench therefore drives whole frames through a task that takes the frame count and a marker option, so each case is one call with a bit count just off the boundary. To show that the unused subframe is ignored, the bench feeds the opposite subframe the bitwise inverse of the block in every frame. The professional CRC cases use blocks whose trailing byte is either the correct CRC or its complement.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

   // Decoded result as published at the block boundary
   typedef struct packed {
      logic       mode_con;
      logic [4:0] flg;
   } cs_result_t;

   // One step of the reflected serial CRC
   function automatic logic [7:0] crc_step(input logic [7:0] c,
                                            input logic       b,
                                            input logic [7:0] poly_r);
      logic fb;
      fb = b ^ c[0];
      return fb ? ((c >> 1) ^ poly_r) : (c >> 1);
   endfunction

endpackage

// File: rtl/cs_bit_collector.sv
module cs_bit_collector
   import cs_dec_pkg::*;
#(
   parameter int         NBITS     = 192,
   parameter int         CRC_BYTES = 23,
   parameter logic [7:0] CRC_POLY_R = 8'hB8,
   parameter logic [7:0] CRC_INIT  = 8'hFF,
   parameter int         CAT_LO    = 8,
   parameter int         CAT_W     = 7,
   parameter int         GEN_POS   = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sf_valid,
   input  logic             sf_cbit,
   input  logic             sf_is_b,
   input  logic             sf_blk_start,
   input  logic             chan_sel,
   output logic             mark_acc,
   output logic             blk_full,
   output logic [3:0]       lead_bits,
   output logic [CAT_W-1:0] cat_bits,
   output logic             gen_bit,
   output logic [7:0]       crc_calc,
   output logic [7:0]       crc_ref
);

   localparam int CW       = $clog2(NBITS + 2);
   localparam int CRC_BITS = CRC_BYTES * 8;
   localparam logic [CW-1:0] UNSYNC = CW'(NBITS + 1);
   localparam logic [CW-1:0] FULL   = CW'(NBITS);
   localparam logic [CW-1:0] CRC_END = CW'(CRC_BITS);

   initial begin
      assert (NBITS % 8 == 0) else $error("NBITS must be whole bytes");
      assert (CRC_BITS + 8 <= NBITS) else $error("CRC field outside block");
      assert (CAT_LO + CAT_W <= NBITS && GEN_POS < NBITS) else $error("field outside block");
   end

   logic [NBITS-1:0] sr_q;
   logic [CW-1:0]    cnt_q;
   logic [7:0]       crc_q;
   logic             acc;

   assign acc      = sf_valid && (sf_is_b == chan_sel);
   assign mark_acc = acc && sf_blk_start;
   assign blk_full = (cnt_q == FULL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q  <= '0;
         cnt_q <= UNSYNC;
         crc_q <= CRC_INIT;
      end else if (acc) begin
         if (sf_blk_start) begin
            sr_q  <= {sf_cbit, sr_q[NBITS-1:1]};
            cnt_q <= CW'(1);
            crc_q <= crc_step(CRC_INIT, sf_cbit, CRC_POLY_R);
         end else if (cnt_q != UNSYNC) begin
            sr_q  <= {sf_cbit, sr_q[NBITS-1:1]};
            cnt_q <= (cnt_q == FULL) ? UNSYNC : cnt_q + CW'(1);
            if (cnt_q < CRC_END)
               crc_q <= crc_step(crc_q, sf_cbit, CRC_POLY_R);
         end
      end
   end

   assign lead_bits = sr_q[3:0];
   assign cat_bits  = sr_q[CAT_LO +: CAT_W];
   assign gen_bit   = sr_q[GEN_POS];
   assign crc_calc  = crc_q;
   assign crc_ref   = sr_q[CRC_BITS +: 8];

   AST_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (sf_valid && sf_is_b != chan_sel) |=> ($stable(cnt_q) && $stable(sr_q))); // R1
   AST_MARK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      mark_acc |=> (cnt_q == CW'(1))); // R7
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= UNSYNC); // R8

endmodule

// File: rtl/cs_field_decode.sv
module cs_field_decode
   import cs_dec_pkg::*;
#(
   parameter int CAT_W   = 7,
   parameter bit USE_CRC = 1'b1
) (
   input  logic [3:0]       lead_bits,
   input  logic [CAT_W-1:0] cat_bits,
   input  logic             gen_bit,
   input  logic [7:0]       crc_calc,
   input  logic [7:0]       crc_ref,
   output cs_result_t       res
);

   initial assert (CAT_W >= 2) else $error("category field too narrow");

   logic pro_ce;

   generate
      if (USE_CRC) begin : g_crc
         assign pro_ce = (crc_calc == crc_ref);
      end else begin : g_nocrc
         logic unused_crc;
         assign unused_crc = ^{crc_calc, crc_ref};
         assign pro_ce = 1'b1;
      end
   endgenerate

   always_comb begin
      res.mode_con = ~lead_bits[0];
      res.flg[0]   = lead_bits[1];
      if (res.mode_con) begin
         res.flg[1] = ~lead_bits[2];
         res.flg[2] = ~lead_bits[3];
         res.flg[3] = gen_bit;
         res.flg[4] = |cat_bits;
      end else begin
         res.flg[1] = lead_bits[2];
         res.flg[2] = lead_bits[3];
         res.flg[3] = ~cat_bits[1];
         res.flg[4] = pro_ce;
      end
   end

endmodule

// File: rtl/cs_block_decoder.sv
module cs_block_decoder
   import cs_dec_pkg::*;
#(
   parameter int         NBITS      = 192,
   parameter int         CRC_BYTES  = 23,
   parameter logic [7:0] CRC_POLY_R = 8'hB8,
   parameter logic [7:0] CRC_INIT   = 8'hFF,
   parameter bit         USE_CRC    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sf_valid,
   input  logic       sf_cbit,
   input  logic       sf_is_b,
   input  logic       sf_blk_start,
   input  logic       chan_sel,
   output logic [4:0] cs_flags,
   output logic       mode_consumer,
   output logic       blk_stb
);

   localparam int CAT_LO  = 8;
   localparam int CAT_W   = 7;
   localparam int GEN_POS = 15;

   logic             mark_acc, blk_full, gen_bit;
   logic [3:0]       lead_bits;
   logic [CAT_W-1:0] cat_bits;
   logic [7:0]       crc_calc, crc_ref;
   cs_result_t       res_d, res_q;
   logic             stb_q;

   cs_bit_collector #(
      .NBITS(NBITS), .CRC_BYTES(CRC_BYTES), .CRC_POLY_R(CRC_POLY_R),
      .CRC_INIT(CRC_INIT), .CAT_LO(CAT_LO), .CAT_W(CAT_W), .GEN_POS(GEN_POS)
   ) u_collect (
      .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_cbit(sf_cbit),
      .sf_is_b(sf_is_b), .sf_blk_start(sf_blk_start), .chan_sel(chan_sel),
      .mark_acc(mark_acc), .blk_full(blk_full), .lead_bits(lead_bits),
      .cat_bits(cat_bits), .gen_bit(gen_bit), .crc_calc(crc_calc),
      .crc_ref(crc_ref)
   );

   cs_field_decode #(.CAT_W(CAT_W), .USE_CRC(USE_CRC)) u_decode (
      .lead_bits(lead_bits), .cat_bits(cat_bits), .gen_bit(gen_bit),
      .crc_calc(crc_calc), .crc_ref(crc_ref), .res(res_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q <= '{mode_con: 1'b1, flg: 5'b0};
         stb_q <= 1'b0;
      end else begin
         stb_q <= mark_acc && blk_full;
         if (mark_acc && blk_full)
            res_q <= res_d;
      end
   end

   assign cs_flags      = res_q.flg;
   assign mode_consumer = res_q.mode_con;
   assign blk_stb       = stb_q;

   AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      blk_stb |=> !blk_stb); // R6
   AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_stb |-> ($stable(cs_flags) && $stable(mode_consumer))); // R7
   AST_PRO_CD: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_stb && !mode_consumer) |-> (cs_flags[3] == !$past(cat_bits[1]))); // R4
   AST_MODE_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
      blk_stb |-> (mode_consumer == !$past(lead_bits[0]))); // R2

endmodule

// File: tb/cs_block_decoder_tb.sv
module cs_block_decoder_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sf_valid = 1'b0, sf_cbit = 1'b0, sf_is_b = 1'b0, sf_blk_start = 1'b0;
   logic       chan_sel = 1'b0;
   logic [4:0] cs_flags;
   logic       mode_consumer, blk_stb;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   cs_block_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_cbit(sf_cbit),
      .sf_is_b(sf_is_b), .sf_blk_start(sf_blk_start), .chan_sel(chan_sel),
      .cs_flags(cs_flags), .mode_consumer(mode_consumer), .blk_stb(blk_stb)
   );

   // {pro, b1, b2, b3, b15, cat[6:0], bad_crc}
   localparam logic [12:0] VEC [6] = '{
      13'b0_0_1_0_0_0000000_0,
      13'b0_1_0_1_1_0010000_0,
      13'b1_0_1_0_0_0000000_0,
      13'b1_1_0_1_1_0000010_1,
      13'b0_0_0_0_0_0000001_0,
      13'b1_1_1_1_0_1111111_0
   };

   function automatic logic [7:0] ref_crc(input logic [191:0] b);
      logic [7:0] c = 8'hFF;
      for (int i = 0; i < 184; i++) begin
         logic fb = b[i] ^ c[0];
         c = c >> 1;
         if (fb) c = c ^ 8'hB8;
      end
      return c;
   endfunction

   function automatic logic [191:0] build(input logic [12:0] v, input int k);
      logic [191:0] b;
      for (int i = 0; i < 192; i++) b[i] = (((i * 5 + k) % 7) < 3);
      b[0] = v[12]; b[1] = v[11]; b[2] = v[10]; b[3] = v[9];
      b[15] = v[8]; b[14:8] = v[7:1];
      b[191:184] = v[0] ? ~ref_crc(b) : ref_crc(b);
      return b;
   endfunction

   // expected {mode_consumer, flags[4:0]}
   function automatic logic [5:0] expect_of(input logic [191:0] b);
      logic [4:0] f;
      f[0] = b[1];
      if (!b[0]) begin
         f[1] = !b[2]; f[2] = !b[3]; f[3] = b[15]; f[4] = |b[14:8];
      end else begin
         f[1] = b[2]; f[2] = b[3]; f[3] = !b[9]; f[4] = (ref_crc(b) == b[191:184]);
      end
      return {!b[0], f};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_sf(input logic isb, input logic bitv, input logic mark);
      @(negedge clk);
      sf_valid = 1'b1; sf_is_b = isb; sf_cbit = bitv; sf_blk_start = mark;
      @(negedge clk);
      sf_valid = 1'b0; sf_blk_start = 1'b0;
   endtask

   // Sends frames: selected subframe gets blk, the other gets its inverse.
   task automatic send_frames(input logic [191:0] blk, input int n, input bit first_mark,
                              input bit exp_pub, input logic [5:0] exp, input string tag);
      logic [5:0] held;
      logic [191:0] ba, bb;
      held = {mode_consumer, cs_flags};
      ba = chan_sel ? ~blk : blk;
      bb = chan_sel ? blk : ~blk;
      for (int i = 0; i < n; i++) begin
         bit m = first_mark && (i == 0);
         send_sf(1'b0, ba[i % 192], m);
         check("R6 strobe on A", blk_stb, m && exp_pub && !chan_sel);
         send_sf(1'b1, bb[i % 192], m);
         check("R6 strobe on B", blk_stb, m && exp_pub && chan_sel);
         if (m) check(tag, {mode_consumer, cs_flags}, exp_pub ? exp : held);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset flags", cs_flags, 5'b0);
      check("R9 reset mode", mode_consumer, 1'b1);
      check("R9 reset strobe", blk_stb, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [191:0] prev, cur, p, q, r, s, t;
      chan_sel = 1'b0;
      do_reset();

      // R8: unmarked stream after reset never publishes
      send_frames(build(VEC[0], 9), 192, 1'b0, 1'b0, 6'b0, "R8 unsynced");

      // Table walk, subframe A selected; B carries inverse data (R1)
      prev = '0;
      for (int k = 0; k < 6; k++) begin
         cur = build(VEC[k], k);
         if (k == 0) send_frames(cur, 192, 1'b1, 1'b0, 6'b0, "R8 first marker");
         else begin
            send_frames(cur, 1, 1'b1, 1'b1, expect_of(prev),
                        prev[0] ? "R4 pro flags (R1 subframe A)" : "R3 consumer flags (R1 subframe A)");
            check("R2 mode bit", mode_consumer, !prev[0]);
            if (prev[0]) check("R5 CRC flag", cs_flags[4], (ref_crc(prev) == prev[191:184]));
            send_frames({1'b0, cur[191:1]}, 191, 1'b0, 1'b0, 6'b0, "none");
         end
         prev = cur;
      end
      // Note: the 191-frame tail above shifts so that frame i carries cur[i+1].

      p = build(VEC[0], 6);
      send_frames(p, 192, 1'b1, 1'b1, expect_of(prev), "R4 last table vector");
      check("R5 CRC pass", cs_flags[4], 1'b1);
      q = build(VEC[1], 7);
      send_frames(q, 100, 1'b1, 1'b1, expect_of(p), "R3 publish before partial");
      r = build(VEC[3], 8);
      send_frames(r, 192, 1'b1, 1'b0, 6'b0, "R7 partial block held");
      s = build(VEC[4], 10);
      send_frames(s, 193, 1'b1, 1'b1, expect_of(r), "R5 CRC fail published");
      check("R5 CRC fail flag", cs_flags[4], 1'b0);
      t = build(VEC[2], 11);
      send_frames(t, 192, 1'b1, 1'b0, 6'b0, "R8 overrun held");
      send_frames(s, 1, 1'b1, 1'b1, expect_of(t), "R6 full block after overrun");

      // R1: subframe B selected, A carries inverse
      do_reset();
      chan_sel = 1'b1;
      cur = build(VEC[5], 12);
      send_frames(cur, 192, 1'b1, 1'b0, 6'b0, "R8 first marker B");
      send_frames(cur, 1, 1'b1, 1'b1, expect_of(cur), "R1 subframe B decoded");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule